// File: doc/BRIEF.md
# Loop Address Generator with Multiply-Accumulate

This block runs the memory side and the counting side of a simple loop for a reconfigurable fabric, so the fabric does not have to build them. Software or a host first loads five configuration registers through a small write port. These hold the first address, a signed address step, a trip count, a coefficient and the starting value of the accumulator. A start pulse then launches the loop.

Once launched, the block issues one memory read per cycle to a synchronous memory that answers one cycle later. The address advances by the step after every read. The block keeps its own remaining-iteration counter and decides by itself when the loop ends.

Each returned word passes through three working registers: a data register, a coefficient register and a product register. The word is multiplied by the coefficient and added into a 32-bit accumulator, which keeps only the low 32 bits. A one-cycle done pulse marks the moment the final sum becomes visible. The sum then stays on the output until the next accepted start.

Top module: `lag_top`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, done and mem_re are 0 and acc_out is 0.
- R2: A configuration write (cfg_we high) loads cfg_wdata into the register chosen by cfg_sel: 0 = first address, 1 = step, 2 = trip count, 3 = coefficient, 4 = accumulator start value. Writes made while busy is high are ignored, so a later run with no new writes behaves exactly as the earlier one.
- R3: start is accepted only while busy is low. A start pulse while busy is high changes neither the read sequence nor the result. busy is high from the cycle after an accepted start through the cycle before done, and is never high for a trip count of zero.
- R4: If start is high in cycle c and the trip count is N > 0, then mem_re is high in exactly cycles c+1 to c+N. Read k (k = 0 to N-1) uses the address first + k*step modulo 2^AW, so a step of all ones walks downward and wraps below zero.
- R5: When done is high, acc_out equals the start value plus the sum over all reads of word times coefficient, reduced modulo 2^32.
- R6: For N > 0, done is high for exactly one cycle, namely cycle c+N+4, and busy is low in that cycle.
- R7: For a trip count of zero, done is high in cycle c+1 only, no read is issued, and acc_out equals the start value.
- R8: While busy is low and no start arrives, acc_out does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | DW | Configuration write data |
| start | input | 1 | Launch request |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | DW | Read data, valid one cycle after the strobe |
| busy | output | 1 | Loop in progress |
| done | output | 1 | One-cycle end-of-loop pulse |
| acc_out | output | DW | Accumulator value |

## Verification
Take start high in cycle c. The read strobe is due in cycles c+1 to c+N. The returned word lands in the data register one cycle after the memory answers. The product is formed the cycle after that, and the sum the cycle after the product. This puts both done and the final accumulator value in cycle c+N+4. For a zero trip count, done is due in cycle c+1.

Each scenario counts cycles from the start pulse and samples every output on the falling clock edge. It compares the strobe, the address, busy and done against these cycle numbers on every cycle of the run. It reads the accumulator only in the cycle where done is due, so any skew of even one register stage is reported.

// File: rtl/lag_pkg.sv
package lag_pkg;
  localparam logic [2:0] SEL_FIRST = 3'd0;
  localparam logic [2:0] SEL_STEP  = 3'd1;
  localparam logic [2:0] SEL_TRIPS = 3'd2;
  localparam logic [2:0] SEL_COEF  = 3'd3;
  localparam logic [2:0] SEL_SEED  = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2
  } lag_state_e;
endpackage

// File: rtl/lag_cfg_bank.sv
module lag_cfg_bank
  import lag_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [2:0]    sel,
  input  logic [DW-1:0] wdata,
  input  logic          lock,
  output logic [AW-1:0] first_q,
  output logic [AW-1:0] step_q,
  output logic [CW-1:0] trips_q,
  output logic [DW-1:0] coef_q,
  output logic [DW-1:0] seed_q
);
  // Register bank; writes are dropped while a loop is running.
  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= '0;
      step_q  <= '0;
      trips_q <= '0;
      coef_q  <= '0;
      seed_q  <= '0;
    end else if (we && !lock) begin
      case (sel)
        SEL_FIRST: first_q <= wdata[AW-1:0];
        SEL_STEP:  step_q  <= wdata[AW-1:0];
        SEL_TRIPS: trips_q <= wdata[CW-1:0];
        SEL_COEF:  coef_q  <= wdata;
        SEL_SEED:  seed_q  <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lag_loop_ctl.sv
module lag_loop_ctl
  import lag_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] first,
  input  logic [AW-1:0] step,
  input  logic [CW-1:0] trips,
  input  logic          fin,
  output logic          launch,
  output logic          busy,
  output logic          done,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic          issue_last
);
  lag_state_e    state_q;
  logic [CW-1:0] remain_q;

  assign launch = start && (state_q == ST_IDLE);
  assign busy   = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      remain_q   <= '0;
      mem_re     <= 1'b0;
      mem_addr   <= '0;
      issue_last <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (trips == '0) begin
              done <= 1'b1;
            end else begin
              state_q    <= ST_ISSUE;
              mem_re     <= 1'b1;
              mem_addr   <= first;
              remain_q   <= trips - 1'b1;
              issue_last <= (trips == CW'(1));
            end
          end
        end
        ST_ISSUE: begin
          if (remain_q == '0) begin
            state_q    <= ST_DRAIN;
            mem_re     <= 1'b0;
            issue_last <= 1'b0;
          end else begin
            mem_addr   <= mem_addr + step;
            remain_q   <= remain_q - 1'b1;
            issue_last <= (remain_q == CW'(1));
          end
        end
        ST_DRAIN: begin
          if (fin) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lag_mac.sv
module lag_mac #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic [DW-1:0] seed,
  input  logic [DW-1:0] coef,
  input  logic          rd_issue,
  input  logic          rd_last,
  input  logic [DW-1:0] rdata,
  output logic          fin,
  output logic [DW-1:0] acc_out
);
  // Working registers: wreg0 data, wreg1 coefficient, wreg2 product.
  logic [DW-1:0] wreg0, wreg1, wreg2;
  logic v1, v2, v3, l1, l2, l3;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      l1 <= 1'b0; l2 <= 1'b0; l3 <= 1'b0;
      wreg0 <= '0; wreg1 <= '0; wreg2 <= '0;
      acc_out <= '0;
    end else begin
      v1 <= rd_issue;
      l1 <= rd_issue && rd_last;
      v2 <= v1;
      l2 <= l1;
      v3 <= v2;
      l3 <= l2;
      if (v1) wreg0 <= rdata;
      if (v2) wreg2 <= wreg0 * wreg1;
      if (launch) begin
        wreg1   <= coef;
        acc_out <= seed;
      end else if (v3) begin
        acc_out <= acc_out + wreg2;
      end
    end
  end

  assign fin = v3 && l3;
endmodule

// File: rtl/lag_top.sv
module lag_top #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          start,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] acc_out
);
  logic [AW-1:0] first_q, stride_q;
  logic [CW-1:0] trips_q;
  logic [DW-1:0] coef_q, seed_q;
  logic launch, fin, issue_last;

  lag_cfg_bank #(.AW(AW), .CW(CW), .DW(DW)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .lock(busy), .first_q(first_q), .step_q(stride_q), .trips_q(trips_q),
    .coef_q(coef_q), .seed_q(seed_q)
  );

  lag_loop_ctl #(.AW(AW), .CW(CW)) u_ctl (
    .clk(clk), .rst(rst), .start(start), .first(first_q), .step(stride_q),
    .trips(trips_q), .fin(fin), .launch(launch), .busy(busy), .done(done),
    .mem_re(mem_re), .mem_addr(mem_addr), .issue_last(issue_last)
  );

  lag_mac #(.DW(DW)) u_mac (
    .clk(clk), .rst(rst), .launch(launch), .seed(seed_q), .coef(coef_q),
    .rd_issue(mem_re), .rd_last(issue_last), .rdata(mem_rdata),
    .fin(fin), .acc_out(acc_out)
  );
endmodule

// File: rtl/lag_chk.sv
module lag_chk #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          mem_re,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] acc_out,
  input logic [AW-1:0] stride
);
  p_re_in_busy_r4: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> busy);

  p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_re && $past(mem_re)) |-> (mem_addr == AW'($past(mem_addr) + $past(stride))));

  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_acc_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(acc_out));
endmodule

bind lag_top lag_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .mem_re(mem_re), .mem_addr(mem_addr), .acc_out(acc_out), .stride(stride_q)
);

// File: tb/lag_top_tb_top.sv
`timescale 1ns/1ps
module lag_top_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic start = 1'b0;
  logic mem_re;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic busy, done;
  logic [DW-1:0] acc_out;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [DW-1:0] last_exp = '0;

  always #2 clk = ~clk;

  lag_top #(.AW(AW), .CW(16), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .start(start), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .busy(busy),
    .done(done), .acc_out(acc_out)
  );

  function automatic logic [DW-1:0] mword(input logic [AW-1:0] a);
    return {a, ~a} ^ 32'h5A5A_1234;
  endfunction

  // Synchronous memory, one cycle read latency.
  always @(posedge clk) if (mem_re) mem_rdata <= mword(mem_addr);

  task automatic check(input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [2:0] sel, input logic [DW-1:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_case(input bit prog, input logic [AW-1:0] first,
                          input logic [AW-1:0] step, input int n,
                          input logic [DW-1:0] coef, input logic [DW-1:0] seed,
                          input bit disturb, input string tag);
    logic [DW-1:0] exp_acc;
    logic [AW-1:0] eaddr;
    int done_cyc, busy_last, re_err, addr_err, busy_err, done_err;
    if (prog) begin
      cfg_wr(3'd0, DW'(first));
      cfg_wr(3'd1, DW'(step));
      cfg_wr(3'd2, DW'(n));
      cfg_wr(3'd3, coef);
      cfg_wr(3'd4, seed);
    end
    exp_acc = seed;
    eaddr = first;
    for (int k = 0; k < n; k++) begin
      exp_acc = exp_acc + mword(eaddr) * coef;
      eaddr = eaddr + step;
    end
    eaddr = first;
    done_cyc  = (n == 0) ? 1 : n + 4;
    busy_last = (n == 0) ? 0 : n + 3;
    re_err = 0; addr_err = 0; busy_err = 0; done_err = 0;
    @(negedge clk);
    start = 1'b1;
    for (int j = 1; j <= done_cyc + 2; j++) begin
      @(negedge clk);
      if (mem_re !== (j <= n)) re_err++;
      if (j <= n) begin
        if (mem_addr !== eaddr) addr_err++;
        eaddr = eaddr + step;
      end
      if (busy !== (j <= busy_last)) busy_err++;
      if (done !== (j == done_cyc)) done_err++;
      if (j == done_cyc)
        check(acc_out === exp_acc, {tag, " R5 accumulated sum"}, acc_out, exp_acc);
      if (j == 1) start = 1'b0;
      if (disturb) begin
        if (j == 2) start = 1'b1;
        if (j == 3) begin start = 1'b0; cfg_we = 1'b1; cfg_sel = 3'd2; cfg_wdata = 32'd1; end
        if (j == 4) begin cfg_sel = 3'd3; cfg_wdata = 32'd0; end
        if (j == 5) cfg_we = 1'b0;
      end
    end
    check(re_err == 0, {tag, " R4 read strobe window"}, re_err, 0);
    check(addr_err == 0, {tag, " R4 address sequence"}, addr_err, 0);
    check(busy_err == 0, {tag, " R3 busy window"}, busy_err, 0);
    check(done_err == 0, {tag, " R6 done timing"}, done_err, 0);
    last_exp = exp_acc;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1 busy/done in reset", {busy, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(mem_re === 1'b0, "R1 mem_re after reset", mem_re, 0);
    check(busy === 1'b0 && done === 1'b0, "R1 busy/done after reset", {busy, done}, 0);
    check(acc_out === '0, "R1 acc after reset", acc_out, 0);
  endtask

  task automatic t_hold();
    logic [DW-1:0] snap;
    snap = acc_out;
    repeat (8) @(negedge clk);
    check(acc_out === snap && acc_out === last_exp, "R8 acc held while idle", acc_out, last_exp);
    check(done === 1'b0, "R8 no stray done while idle", done, 0);
  endtask

  initial begin
    t_reset();
    run_case(1'b1, 16'h0010, 16'h0001, 5, 32'd3, 32'd0, 1'b0, "basic");
    run_case(1'b1, 16'h0002, 16'hFFFF, 6, 32'hFFFF_FFF3, 32'h1234, 1'b0, "R4 down-wrap R5 overflow");
    run_case(1'b1, 16'h0100, 16'h0004, 1, 32'd7, 32'd5, 1'b0, "R6 single trip");
    t_hold();
    run_case(1'b1, 16'h0200, 16'h0003, 0, 32'd9, 32'hABCD, 1'b0, "R7 zero trips");
    run_case(1'b1, 16'h0040, 16'h0008, 6, 32'd11, 32'd1, 1'b1, "R3 R2 start and writes while busy");
    run_case(1'b0, 16'h0040, 16'h0008, 6, 32'd11, 32'd1, 1'b0, "R2 rerun keeps config");
    t_hold();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule